// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only line cache made of two stores that are searched together on every request. The first store is direct-mapped: each line address has exactly one set it can live in. The second store is a small fully associative buffer. It keeps the lines that the first store recently pushed out, so that two or three addresses fighting over the same set can still hit. All lines are clean, so a line that leaves the buffer is simply dropped.

A processor-side port takes one word address at a time and returns one word with a source code. A memory-side port asks for a whole line by line address and accepts the line in a single beat.

- A main-store hit and a victim-buffer hit answer one cycle after the request is accepted.
- A victim-buffer hit swaps the two lines in that same cycle.
- A miss in both stores fetches the line from memory and installs it in the main store. The line it displaces moves to the victim buffer.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset both stores are empty, `cpu_req_ready` is 1, `cpu_resp_valid` and `mem_req_valid` are 0, and the first access to any address is served from memory.
- R2: A request whose line is in the main store returns its word one cycle after acceptance with `cpu_resp_src` = 1, and no memory request is made.
- R3: The victim buffer is searched in parallel with the main store. A request whose line is only in the victim buffer returns its word one cycle after acceptance with `cpu_resp_src` = 2, and no memory request is made.
- R4: On a victim-buffer hit, the requested line moves into its main-store set and the line that was there moves into the victim entry that hit. Both moves finish before the next request is accepted.
- R5: On a miss in both stores, `mem_req_valid` rises the cycle after acceptance with `mem_req_line_addr` = request address without its word-offset bits. The address stays stable until `mem_resp_valid`, and `cpu_req_ready` stays 0 for that whole time.
- R6: The cycle after `mem_resp_valid`, the block returns the requested word from the fetched line with `cpu_resp_src` = 3, installs the line in the main store, and raises `cpu_req_ready` again.
- R7: When a fill replaces a valid main-store line, that line is written into the victim buffer with its full line address (tag and set index).
- R8: The victim entry written on a fill is the lowest-numbered invalid entry. When every entry is valid, a round-robin pointer is used instead. It starts at entry 0 and advances by one, wrapping, after each such use.
- R9: A fill into a set that held no valid line writes nothing into the victim buffer.
- R10: A line address is held in at most one place: never in both stores, and in at most one victim entry.
- R11: The word offset is the low log2(LINE_WORDS) bits of the address. Word w of a line sits at bits [w*WORD_W +: WORD_W]. The set index is the next log2(SETS) bits, and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Request present |
| cpu_req_ready | output | 1 | Request is accepted at this edge when valid |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_resp_valid | output | 1 | One-cycle response strobe |
| cpu_resp_data | output | WORD_W | Requested word |
| cpu_resp_src | output | 2 | 1 main store, 2 victim buffer, 3 memory |
| mem_req_valid | output | 1 | Line fetch outstanding |
| mem_req_line_addr | output | ADDR_W-log2(LINE_WORDS) | Line address being fetched |
| mem_resp_valid | input | 1 | Fetched line present this cycle |
| mem_resp_line | input | WORD_W*LINE_WORDS | Fetched line, word 0 in the low bits |

## Verification
The assertions check on every cycle the one-home rule for line addresses, the single-match rule inside the victim buffer, the one-cycle answer on either kind of hit, and the ordering of a memory fetch: request raised, address held, ready low, response after fill.

Only the bench's scenarios can show the contents behaviour. These are:
- a line leaving a set and coming back through a swap;
- the order in which victim entries are recycled;
- empty sets contributing no victim;
- the correct word being returned.

The bench compares every response against a reference model of both stores, under alternating same-set traffic and random conflict-heavy traffic.

// File: rtl/vc_pkg.sv
package vc_pkg;

    // Source of a returned word, as seen on cpu_resp_src.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_VICT = 2'd2,
        SRC_MEM  = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctl_st_e;

endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
    parameter int SETS   = 32,
    parameter int TAG_W  = 13,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);

    typedef struct packed {
        logic [SETS-1:0]             vld;
        logic [SETS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][LINE_W-1:0] line;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (wr_en) begin
            arr_d.vld[wr_idx]  = 1'b1;
            arr_d.tag[wr_idx]  = wr_tag;
            arr_d.line[wr_idx] = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    assign rd_valid = arr_q.vld[rd_idx];
    assign rd_tag   = arr_q.tag[rd_idx];
    assign rd_line  = arr_q.line[rd_idx];

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
    parameter int ENTRIES = 16,
    parameter int LADDR_W = 18,
    parameter int LINE_W  = 128,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LADDR_W-1:0] lk_laddr,
    output logic               lk_hit,
    output logic [SLOT_W-1:0]  lk_slot,
    output logic [LINE_W-1:0]  lk_line,
    output logic [ENTRIES-1:0] lk_hit_vec,
    output logic [SLOT_W-1:0]  alloc_slot,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic               wr_valid,
    input  logic [LADDR_W-1:0] wr_laddr,
    input  logic [LINE_W-1:0]  wr_line,
    input  logic               wr_alloc
);

    typedef struct packed {
        logic [ENTRIES-1:0]              vld;
        logic [ENTRIES-1:0][LADDR_W-1:0] laddr;
        logic [ENTRIES-1:0][LINE_W-1:0]  line;
        logic [SLOT_W-1:0]               rr;
    } vb_t;

    vb_t vb_d, vb_q;
    logic all_vld;

    // Parallel comparators, one per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign lk_hit_vec[g] = vb_q.vld[g] && (vb_q.laddr[g] == lk_laddr);
    end

    assign lk_hit  = |lk_hit_vec;
    assign all_vld = &vb_q.vld;

    always_comb begin
        lk_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i]) lk_slot = SLOT_W'(i);
        end
    end

    assign lk_line = vb_q.line[lk_slot];

    // Lowest invalid entry wins; round-robin pointer when full.
    always_comb begin
        alloc_slot = vb_q.rr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vb_q.vld[i]) alloc_slot = SLOT_W'(i);
        end
    end

    always_comb begin
        vb_d = vb_q;
        if (wr_en) begin
            vb_d.vld[wr_slot]   = wr_valid;
            vb_d.laddr[wr_slot] = wr_laddr;
            vb_d.line[wr_slot]  = wr_line;
            if (wr_alloc && all_vld) begin
                if (vb_q.rr == SLOT_W'(ENTRIES - 1)) vb_d.rr = '0;
                else                                 vb_d.rr = vb_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vb_q <= '0;
        else        vb_q <= vb_d;
    end

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vc_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 32,
    parameter int ENTRIES    = 16,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = WORD_W * LINE_WORDS,
    localparam int SLOT_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req_valid,
    output logic               cpu_req_ready,
    input  logic [ADDR_W-1:0]  cpu_req_addr,
    output logic               cpu_resp_valid,
    output logic [WORD_W-1:0]  cpu_resp_data,
    output logic [1:0]         cpu_resp_src,
    output logic               mem_req_valid,
    output logic [LADDR_W-1:0] mem_req_line_addr,
    input  logic               mem_resp_valid,
    input  logic [LINE_W-1:0]  mem_resp_line,
    // lookup
    output logic [IDX_W-1:0]   lk_idx,
    output logic [LADDR_W-1:0] lk_laddr,
    output logic               main_hit,
    input  logic               m_valid,
    input  logic [TAG_W-1:0]   m_tag,
    input  logic [LINE_W-1:0]  m_line,
    input  logic               vb_hit,
    input  logic [SLOT_W-1:0]  vb_hit_slot,
    input  logic [LINE_W-1:0]  vb_line,
    input  logic [SLOT_W-1:0]  vb_alloc_slot,
    // main store write
    output logic               main_we,
    output logic [TAG_W-1:0]   main_wtag,
    output logic [LINE_W-1:0]  main_wline,
    // victim buffer write
    output logic               vb_we,
    output logic [SLOT_W-1:0]  vb_wslot,
    output logic               vb_wvalid,
    output logic [LADDR_W-1:0] vb_wladdr,
    output logic [LINE_W-1:0]  vb_wline,
    output logic               vb_walloc
);

    typedef struct packed {
        ctl_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_d;
        src_e              rsp_k;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [OFF_W-1:0]  cur_off;
    logic [TAG_W-1:0]  cur_tag;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                    input logic [OFF_W-1:0]  off);
        logic [LINE_WORDS-1:0][WORD_W-1:0] words;
        words = ln;
        return words[off];
    endfunction

    // While idle, look up the incoming address; during a fill, the held one.
    assign cur_addr = (c_q.st == ST_IDLE) ? cpu_req_addr : c_q.addr;
    assign cur_off  = cur_addr[OFF_W-1:0];
    assign lk_idx   = cur_addr[OFF_W +: IDX_W];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign lk_laddr = cur_addr[ADDR_W-1:OFF_W];
    assign main_hit = m_valid && (m_tag == cur_tag);

    always_comb begin
        c_d        = c_q;
        c_d.rsp_v  = 1'b0;
        main_we    = 1'b0;
        main_wtag  = cur_tag;
        main_wline = vb_line;
        vb_we      = 1'b0;
        vb_wslot   = vb_hit_slot;
        vb_wvalid  = m_valid;
        vb_wladdr  = {m_tag, lk_idx};
        vb_wline   = m_line;
        vb_walloc  = 1'b0;
        mem_req_valid = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    c_d.addr = cpu_req_addr;
                    if (main_hit) begin
                        c_d.rsp_v = 1'b1;
                        c_d.rsp_d = pick_word(m_line, cur_off);
                        c_d.rsp_k = SRC_MAIN;
                    end else if (vb_hit) begin
                        // swap: buffer line to main set, main line to that entry
                        c_d.rsp_v = 1'b1;
                        c_d.rsp_d = pick_word(vb_line, cur_off);
                        c_d.rsp_k = SRC_VICT;
                        main_we   = 1'b1;
                        vb_we     = 1'b1;
                    end else begin
                        c_d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_resp_valid) begin
                    main_we    = 1'b1;
                    main_wline = mem_resp_line;
                    vb_we      = m_valid;
                    vb_wslot   = vb_alloc_slot;
                    vb_wvalid  = 1'b1;
                    vb_walloc  = 1'b1;
                    c_d.rsp_v  = 1'b1;
                    c_d.rsp_d  = pick_word(mem_resp_line, cur_off);
                    c_d.rsp_k  = SRC_MEM;
                    c_d.st     = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cpu_req_ready     = (c_q.st == ST_IDLE);
    assign cpu_resp_valid    = c_q.rsp_v;
    assign cpu_resp_data     = c_q.rsp_d;
    assign cpu_resp_src      = c_q.rsp_k;
    assign mem_req_line_addr = c_q.addr[ADDR_W-1:OFF_W];

endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
    parameter int ADDR_W     = 20,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 32,
    parameter int VB_ENTRIES = 16,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = WORD_W * LINE_WORDS,
    localparam int SLOT_W  = $clog2(VB_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req_valid,
    output logic               cpu_req_ready,
    input  logic [ADDR_W-1:0]  cpu_req_addr,
    output logic               cpu_resp_valid,
    output logic [WORD_W-1:0]  cpu_resp_data,
    output logic [1:0]         cpu_resp_src,
    output logic               mem_req_valid,
    output logic [LADDR_W-1:0] mem_req_line_addr,
    input  logic               mem_resp_valid,
    input  logic [LINE_W-1:0]  mem_resp_line
);

    logic [IDX_W-1:0]      lk_idx;
    logic [LADDR_W-1:0]    lk_laddr;
    logic                  main_hit;
    logic                  m_valid;
    logic [TAG_W-1:0]      m_tag;
    logic [LINE_W-1:0]     m_line;
    logic                  vb_hit;
    logic [SLOT_W-1:0]     vb_hit_slot;
    logic [LINE_W-1:0]     vb_line;
    logic [VB_ENTRIES-1:0] vb_hit_vec;
    logic [SLOT_W-1:0]     vb_alloc_slot;
    logic                  main_we;
    logic [TAG_W-1:0]      main_wtag;
    logic [LINE_W-1:0]     main_wline;
    logic                  vb_we;
    logic [SLOT_W-1:0]     vb_wslot;
    logic                  vb_wvalid;
    logic [LADDR_W-1:0]    vb_wladdr;
    logic [LINE_W-1:0]     vb_wline;
    logic                  vb_walloc;

    vc_main_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_valid(m_valid), .rd_tag(m_tag), .rd_line(m_line),
        .wr_en(main_we), .wr_idx(lk_idx), .wr_tag(main_wtag), .wr_line(main_wline)
    );

    vc_victim_buf #(.ENTRIES(VB_ENTRIES), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_vbuf (
        .clk(clk), .rst_n(rst_n),
        .lk_laddr(lk_laddr), .lk_hit(vb_hit), .lk_slot(vb_hit_slot), .lk_line(vb_line),
        .lk_hit_vec(vb_hit_vec), .alloc_slot(vb_alloc_slot),
        .wr_en(vb_we), .wr_slot(vb_wslot), .wr_valid(vb_wvalid),
        .wr_laddr(vb_wladdr), .wr_line(vb_wline), .wr_alloc(vb_walloc)
    );

    vc_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
              .SETS(SETS), .ENTRIES(VB_ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_addr(cpu_req_addr), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_data(cpu_resp_data), .cpu_resp_src(cpu_resp_src),
        .mem_req_valid(mem_req_valid), .mem_req_line_addr(mem_req_line_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line),
        .lk_idx(lk_idx), .lk_laddr(lk_laddr), .main_hit(main_hit),
        .m_valid(m_valid), .m_tag(m_tag), .m_line(m_line),
        .vb_hit(vb_hit), .vb_hit_slot(vb_hit_slot), .vb_line(vb_line),
        .vb_alloc_slot(vb_alloc_slot),
        .main_we(main_we), .main_wtag(main_wtag), .main_wline(main_wline),
        .vb_we(vb_we), .vb_wslot(vb_wslot), .vb_wvalid(vb_wvalid),
        .vb_wladdr(vb_wladdr), .vb_wline(vb_wline), .vb_walloc(vb_walloc)
    );

endmodule

// File: rtl/vc_checks.sv
module vc_checks #(
    parameter int ENTRIES = 16,
    parameter int LADDR_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req_valid,
    input logic               cpu_req_ready,
    input logic               cpu_resp_valid,
    input logic [1:0]         cpu_resp_src,
    input logic               mem_req_valid,
    input logic [LADDR_W-1:0] mem_req_line_addr,
    input logic               mem_resp_valid,
    input logic               main_hit,
    input logic               vb_hit,
    input logic [ENTRIES-1:0] vb_hit_vec
);

    p_single_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_hit && vb_hit));

    p_match_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vb_hit_vec));

    p_main_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && main_hit
        |=> cpu_resp_valid && cpu_resp_src == 2'd1 && !mem_req_valid);

    p_victim_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && vb_hit
        |=> cpu_resp_valid && cpu_resp_src == 2'd2 && !mem_req_valid);

    p_miss_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && !main_hit && !vb_hit
        |=> mem_req_valid && !cpu_resp_valid);

    p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_line_addr));

    p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    p_fill_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_resp_valid
        |=> cpu_resp_valid && cpu_resp_src == 2'd3 && cpu_req_ready && !mem_req_valid);

endmodule

bind dm_victim_cache vc_checks #(.ENTRIES(VB_ENTRIES), .LADDR_W(LADDR_W)) u_checks (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_src(cpu_resp_src),
    .mem_req_valid(mem_req_valid), .mem_req_line_addr(mem_req_line_addr),
    .mem_resp_valid(mem_resp_valid),
    .main_hit(main_hit), .vb_hit(vb_hit), .vb_hit_vec(vb_hit_vec)
);

// File: tb/dm_victim_cache_test.sv
module dm_victim_cache_test;

    localparam int ADDR_W     = 12;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int SETS       = 8;
    localparam int VB         = 4;
    localparam int OFF_W      = 2;
    localparam int IDX_W      = 3;
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W    = ADDR_W - OFF_W;
    localparam int LINE_W     = WORD_W * LINE_WORDS;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cpu_req_valid = 1'b0;
    logic               cpu_req_ready;
    logic [ADDR_W-1:0]  cpu_req_addr = '0;
    logic               cpu_resp_valid;
    logic [WORD_W-1:0]  cpu_resp_data;
    logic [1:0]         cpu_resp_src;
    logic               mem_req_valid;
    logic [LADDR_W-1:0] mem_req_line_addr;
    logic               mem_resp_valid = 1'b0;
    logic [LINE_W-1:0]  mem_resp_line = '0;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model of both stores
    bit               m_vld [SETS];
    logic [TAG_W-1:0] m_tag [SETS];
    bit               v_vld [VB];
    logic [LADDR_W-1:0] v_la [VB];
    int               rr;

    always #10 clk = ~clk;

    dm_victim_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
                      .SETS(SETS), .VB_ENTRIES(VB)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_addr(cpu_req_addr), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_data(cpu_resp_data), .cpu_resp_src(cpu_resp_src),
        .mem_req_valid(mem_req_valid), .mem_req_line_addr(mem_req_line_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] ref_word(input logic [LADDR_W-1:0] la, input int w);
        return (32'(la) * 32'h0001_0003) ^ (32'(w) * 32'h1111_0000) ^ 32'hC3A5_0F0F;
    endfunction

    function automatic logic [LINE_W-1:0] ref_line(input logic [LADDR_W-1:0] la);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < LINE_WORDS; w++) l[w*WORD_W +: WORD_W] = ref_word(la, w);
        return l;
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int tg, input int ix, input int off);
        return {TAG_W'(tg), IDX_W'(ix), OFF_W'(off)};
    endfunction

    // One access; returns the source kind the model predicted.
    task automatic access(input logic [ADDR_W-1:0] a, input string lbl, output int kind);
        logic [LADDR_W-1:0] la;
        logic [TAG_W-1:0]   tg;
        logic [WORD_W-1:0]  ew;
        int ix, off, slot, dly, tmp_v;
        logic [TAG_W-1:0] tmp_t;
        la  = a[ADDR_W-1:OFF_W];
        tg  = a[ADDR_W-1 -: TAG_W];
        ix  = int'(a[OFF_W +: IDX_W]);
        off = int'(a[OFF_W-1:0]);
        kind = 3; slot = -1;
        if (m_vld[ix] && m_tag[ix] == tg) kind = 1;
        else begin
            for (int s = 0; s < VB; s++)
                if (v_vld[s] && v_la[s] == la) begin kind = 2; slot = s; end
        end
        ew = ref_word(la, off);
        check(cpu_req_ready == 1'b1, "R5 ready before request", 64'(cpu_req_ready), 64'd1);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (kind != 3) begin
            check(cpu_resp_valid == 1'b1, {lbl, " R2/R3 one-cycle answer"}, 64'(cpu_resp_valid), 64'd1);
            check(int'(cpu_resp_src) == kind, {lbl, " source"}, 64'(cpu_resp_src), 64'(kind));
            check(cpu_resp_data == ew, {lbl, " R11 word"}, 64'(cpu_resp_data), 64'(ew));
            check(mem_req_valid == 1'b0, {lbl, " no fetch on hit"}, 64'(mem_req_valid), 64'd0);
        end else begin
            check(mem_req_valid && !cpu_resp_valid && !cpu_req_ready, {lbl, " R5 fetch raised"},
                  64'({mem_req_valid, cpu_resp_valid, cpu_req_ready}), 64'b100);
            check(mem_req_line_addr == la, {lbl, " R5 line address"}, 64'(mem_req_line_addr), 64'(la));
            dly = int'($urandom % 4);
            repeat (dly) begin
                @(negedge clk);
                check(mem_req_valid && mem_req_line_addr == la && !cpu_req_ready, {lbl, " R5 held"},
                      64'(mem_req_line_addr), 64'(la));
            end
            mem_resp_valid = 1'b1;
            mem_resp_line  = ref_line(la);
            @(negedge clk);
            mem_resp_valid = 1'b0;
            check(cpu_resp_valid && cpu_req_ready, {lbl, " R6 fill answer"},
                  64'({cpu_resp_valid, cpu_req_ready}), 64'b11);
            check(cpu_resp_src == 2'd3, {lbl, " R6 source"}, 64'(cpu_resp_src), 64'd3);
            check(cpu_resp_data == ew, {lbl, " R6 R11 word"}, 64'(cpu_resp_data), 64'(ew));
        end
        // model update
        if (kind == 2) begin
            tmp_v = int'(m_vld[ix]); tmp_t = m_tag[ix];
            m_vld[ix] = 1'b1; m_tag[ix] = tg;
            v_vld[slot] = (tmp_v != 0); v_la[slot] = {tmp_t, IDX_W'(ix)};
        end else if (kind == 3) begin
            if (m_vld[ix]) begin
                slot = -1;
                for (int s = VB - 1; s >= 0; s--) if (!v_vld[s]) slot = s;
                if (slot < 0) begin slot = rr; rr = (rr + 1) % VB; end
                v_vld[slot] = 1'b1; v_la[slot] = {m_tag[ix], IDX_W'(ix)};
            end
            m_vld[ix] = 1'b1; m_tag[ix] = tg;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd20240611));
        for (int i = 0; i < SETS; i++) begin m_vld[i] = 0; m_tag[i] = '0; end
        for (int i = 0; i < VB; i++) begin v_vld[i] = 0; v_la[i] = '0; end
        rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cpu_req_ready && !cpu_resp_valid && !mem_req_valid, "R1 reset outputs",
              64'({cpu_req_ready, cpu_resp_valid, mem_req_valid}), 64'b100);

        // R1/R6: first touch comes from memory; R2 then hits main
        access(mk(1, 1, 2), "R1", k);
        check(k == 3, "R1 first access misses", 64'(k), 64'd3);
        access(mk(1, 1, 3), "R2", k);
        check(k == 1, "R2 main hit", 64'(k), 64'd1);

        // R7: conflicting line pushes the first one into the buffer
        access(mk(2, 1, 0), "R7", k);
        check(k == 3, "R7 conflict miss", 64'(k), 64'd3);

        // R3/R4: alternating same-set pair keeps hitting the buffer
        for (int i = 0; i < 8; i++) begin
            access(mk((i % 2 == 0) ? 1 : 2, 1, i % 4), "R4", k);
            check(k == 2, "R3 R4 swap keeps victim hits", 64'(k), 64'd2);
        end
        access(mk(2, 1, 1), "R4", k);
        check(k == 1, "R4 swapped line now in main", 64'(k), 64'd1);

        // R8: VB+2 fresh lines into set 5 cycle the buffer; the oldest is then gone
        for (int t = 10; t < 10 + VB + 2; t++) access(mk(t, 5, 0), "R8", k);
        access(mk(10, 5, 1), "R8", k);
        check(k == 3, "R8 oldest victim recycled", 64'(k), 64'd3);

        // R9: fill into an empty set leaves the buffer untouched
        access(mk(3, 6, 0), "R9", k);
        check(k == 3, "R9 empty-set fill", 64'(k), 64'd3);
        access(mk(11 + VB, 5, 2), "R9", k);
        check(k == 2, "R9 buffer content kept", 64'(k), 64'd2);

        // random conflict-heavy traffic against the model (R10 held by assertions)
        for (int i = 0; i < 1500; i++)
            access(mk(int'($urandom % 6), int'($urandom % 4), int'($urandom % 4)), "RND", k);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule